// File: doc/BRIEF.md
# Shadowed BCD Real-Time Clock Core

This block keeps calendar time in packed BCD: seconds, minutes, hours, day of week, date, month and a two-digit year. It advances once per second, and the second is made by dividing a 32.768 kHz oscillator clock enable. Software never reads or writes the live counters. It works only through a bank of user registers on a small synchronous bus.

Setting the capture bit from 0 to 1 copies one consistent image of the counters into the user bank. Setting the hold bit stops the counters. While the hold bit is set, software updates the user bank. Clearing the hold bit loads the bank into the counters, and counting starts again from the loaded values.

A year rollover raises a century flag, which a bus read of the control register clears. An oscillator halt bit stops all timekeeping. An audit pin carries either a 512 Hz square wave from the same divider or a power-fail input passed through unchanged.

Top module: `rtc_shadow_core`

## Requirements
- R1: The seconds register at address 2 holds the units digit in bits 3:0 (0–9) and the tens digit in bits 6:4 (0–5). Bit 7 always reads 0, and a written bit 7 is discarded.
- R2: The time registers are minutes at address 3, hours at address 4 (00–23), day of week at address 5 (1–7), date at address 6, month at address 7 (01–12) and year at address 8 (00–99). The counters roll over in a chain from seconds up to year. The date wraps after the last day of its month, and February has 29 days when the year is a multiple of 4, including 00.
- R3: When bit 0 of address 0 goes from 0 to 1, the live counters are copied into the user bank. Writing 1 again while the bit is already 1 captures nothing. Between captures, the user bank does not follow the counters.
- R4: While bit 1 of address 0 is 1, the counters hold their values, and seconds that elapse during the hold are dropped.
- R5: When bit 1 of address 0 goes from 1 to 0, the user bank is loaded into the counters, and counting continues from the loaded values.
- R6: When the year rolls over from 99 to 00, bit 6 of address 0 is set.
  - Bus writes do not change this bit.
  - A read strobe on address 0 clears it.
  - If a read strobe falls in the same cycle as a rollover, the flag ends up set.
- R7: Bit 7 of address 1 halts the clock while it is 1. During a halt, the divider does not count and no second elapses.
- R8: Bits 6:0 of address 1 hold the calibration sign (bit 6) and magnitude (bits 5:0). Both read back as written.
- R9: When bit 2 of address 0 is 1, `audit_out` is a square wave that toggles once every AUDIT_DIV/2 oscillator enables. When that bit is 0, `audit_out` equals `pfail_in`.
- R10: Bits 7, 5, 4 and 3 of address 0 read as 0. Unmapped addresses read as 0.
- R11: After reset:
  - address 0 reads 00 and address 1 reads 80;
  - the time reads 00:00:00 with day of week 1, date 01, month 01 and year 00.
- R12: One second elapses for every TICK_DIV oscillator enables that arrive while the clock is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_ce | input | 1 | One-cycle enable at the oscillator rate |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; clears the century flag at address 0 |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pfail_in | input | 1 | Power-fail comparator level |
| audit_out | output | 1 | 512 Hz audit wave or power-fail passthrough |

## Verification
A year rollover that sets the century flag can land in the same cycle as a read strobe on address 0 that clears it. The bench provokes this by sending one enable less than a full second from a loaded time of 23:59:59 on 31 Dec 99. It then asserts the last enable together with the read strobe on address 0. The flag must still read 1 afterwards, the time must read 00:00:00 on 01 Jan 00, and a second read must then clear the flag.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    typedef enum logic [3:0] {
        A_CTRL = 4'h0,
        A_OSC  = 4'h1,
        A_SEC  = 4'h2,
        A_MIN  = 4'h3,
        A_HOUR = 4'h4,
        A_WDAY = 4'h5,
        A_DATE = 4'h6,
        A_MON  = 4'h7,
        A_YEAR = 4'h8
    } reg_addr_e;

    // bit positions in the control and oscillator registers
    localparam int CTL_SNAP = 0;
    localparam int CTL_HOLD = 1;
    localparam int CTL_AUD  = 2;
    localparam int CTL_CENT = 6;
    localparam int OSC_HALT = 7;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [2:0] wday;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] year;
    } tod_t;

    localparam tod_t TOD_RESET = '{sec: 7'h00, min: 7'h00, hour: 6'h00,
                                   wday: 3'd1, date: 6'h01, mon: 5'h01,
                                   year: 8'h00};

    // add one to a two-digit BCD value, no wrap handling
    function automatic logic [7:0] bcd_next(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // last valid date of a month, BCD; leap when year is a multiple of 4
    function automatic logic [5:0] month_last(input logic [4:0] mon, input logic [7:0] yr);
        logic leap;
        leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                     : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
        case (mon)
            5'h02:                      return leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
    parameter int TICK_DIV  = 32768,
    parameter int AUDIT_DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_ce,
    input  logic run,
    output logic tick,
    output logic audit_sq
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int AH = (AUDIT_DIV > 1) ? AUDIT_DIV / 2 : 1;
    localparam int AW = (AH > 1) ? $clog2(AH) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(TICK_DIV - 1);
    localparam logic [AW-1:0] A_LAST = AW'(AH - 1);

    logic          step;
    logic [TW-1:0] tcnt_q;
    logic [AW-1:0] acnt_q;
    logic          sq_q;

    assign step     = osc_ce && run;
    assign tick     = step && (tcnt_q == T_LAST);
    assign audit_sq = sq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt_q <= '0;
            acnt_q <= '0;
            sq_q   <= 1'b0;
        end else if (step) begin
            tcnt_q <= (tcnt_q == T_LAST) ? '0 : tcnt_q + 1'b1;
            if (acnt_q == A_LAST) begin
                acnt_q <= '0;
                sq_q   <= ~sq_q;
            end else begin
                acnt_q <= acnt_q + 1'b1;
            end
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R12

endmodule

// File: rtl/rtc_tod_counters.sv
`timescale 1ns/1ps
module rtc_tod_counters
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic load,
    input  tod_t load_val,
    output tod_t tod,
    output logic year_wrap
);
    tod_t tod_q, nxt;
    logic c_min, c_hour, c_day, c_mon, c_year;

    always_comb begin
        c_min  = adv && (tod_q.sec == 7'h59);
        c_hour = c_min && (tod_q.min == 7'h59);
        c_day  = c_hour && (tod_q.hour == 6'h23);
        c_mon  = c_day && (tod_q.date == month_last(tod_q.mon, tod_q.year));
        c_year = c_mon && (tod_q.mon == 5'h12);
        year_wrap = c_year && (tod_q.year == 8'h99);

        nxt = tod_q;
        if (c_min)      nxt.sec = '0;
        else if (adv)   nxt.sec = 7'(bcd_next({1'b0, tod_q.sec}));
        if (c_hour)     nxt.min = '0;
        else if (c_min) nxt.min = 7'(bcd_next({1'b0, tod_q.min}));
        if (c_day)       nxt.hour = '0;
        else if (c_hour) nxt.hour = 6'(bcd_next({2'b00, tod_q.hour}));
        if (c_day)      nxt.wday = (tod_q.wday == 3'd7) ? 3'd1 : tod_q.wday + 3'd1;
        if (c_mon)      nxt.date = 6'h01;
        else if (c_day) nxt.date = 6'(bcd_next({2'b00, tod_q.date}));
        if (c_year)     nxt.mon = 5'h01;
        else if (c_mon) nxt.mon = 5'(bcd_next({3'b000, tod_q.mon}));
        if (c_year)     nxt.year = (tod_q.year == 8'h99) ? 8'h00 : bcd_next(tod_q.year);
    end

    always_ff @(posedge clk) begin
        if (rst)       tod_q <= TOD_RESET;
        else if (load) tod_q <= load_val;
        else           tod_q <= nxt;
    end

    assign tod = tod_q;

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && tod_q.sec == 7'h59) |=> (tod_q.sec == 7'h00)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load) |=> $stable(tod_q)); // R4
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load |=> (tod_q == $past(load_val))); // R5

endmodule

// File: rtl/rtc_regfile.sv
`timescale 1ns/1ps
module rtc_regfile
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              re,
    input  tod_t              live,
    input  logic              year_wrap,
    output logic [DATA_W-1:0] rdata,
    output logic              hold,
    output logic              halt,
    output logic              aud_sel,
    output logic              load,
    output tod_t              shadow
);
    reg_addr_e a;
    logic      snap_q, hold_q, aud_q, cent_q, halt_q;
    logic [6:0] trim_q;
    tod_t      shadow_q;
    logic      wr_ctrl, snap_rise, cent_clr;

    assign a         = reg_addr_e'(addr);
    assign wr_ctrl   = we && (a == A_CTRL);
    assign snap_rise = wr_ctrl && wdata[CTL_SNAP] && !snap_q;
    assign load      = wr_ctrl && !wdata[CTL_HOLD] && hold_q;
    assign cent_clr  = re && (a == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q   <= 1'b0;
            hold_q   <= 1'b0;
            aud_q    <= 1'b0;
            cent_q   <= 1'b0;
            halt_q   <= 1'b1;
            trim_q   <= '0;
            shadow_q <= TOD_RESET;
        end else begin
            if (wr_ctrl) begin
                snap_q <= wdata[CTL_SNAP];
                hold_q <= wdata[CTL_HOLD];
                aud_q  <= wdata[CTL_AUD];
            end
            // a rollover outranks a clearing read in the same cycle
            if (year_wrap)     cent_q <= 1'b1;
            else if (cent_clr) cent_q <= 1'b0;
            if (we && a == A_OSC) begin
                halt_q <= wdata[OSC_HALT];
                trim_q <= wdata[6:0];
            end
            if (snap_rise) begin
                shadow_q <= live;
            end else if (we) begin
                case (a)
                    A_SEC:   shadow_q.sec  <= wdata[6:0];
                    A_MIN:   shadow_q.min  <= wdata[6:0];
                    A_HOUR:  shadow_q.hour <= wdata[5:0];
                    A_WDAY:  shadow_q.wday <= wdata[2:0];
                    A_DATE:  shadow_q.date <= wdata[5:0];
                    A_MON:   shadow_q.mon  <= wdata[4:0];
                    A_YEAR:  shadow_q.year <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (a)
            A_CTRL:  rdata = {1'b0, cent_q, 3'b000, aud_q, hold_q, snap_q};
            A_OSC:   rdata = {halt_q, trim_q};
            A_SEC:   rdata = {1'b0, shadow_q.sec};
            A_MIN:   rdata = {1'b0, shadow_q.min};
            A_HOUR:  rdata = {2'b00, shadow_q.hour};
            A_WDAY:  rdata = {5'b00000, shadow_q.wday};
            A_DATE:  rdata = {2'b00, shadow_q.date};
            A_MON:   rdata = {3'b000, shadow_q.mon};
            A_YEAR:  rdata = shadow_q.year;
            default: rdata = '0;
        endcase
    end

    assign hold    = hold_q;
    assign halt    = halt_q;
    assign aud_sel = aud_q;
    assign shadow  = shadow_q;

    AST_CENT_SET: assert property (@(posedge clk) disable iff (rst)
        year_wrap |=> cent_q); // R6
    AST_CENT_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cent_clr && !year_wrap) |=> !cent_q); // R6
    AST_SNAP_COPIES: assert property (@(posedge clk) disable iff (rst)
        snap_rise |=> (shadow_q == $past(live))); // R3

endmodule

// File: rtl/rtc_shadow_core.sv
`timescale 1ns/1ps
module rtc_shadow_core
    import rtc_pkg::*;
#(
    parameter int TICK_DIV  = 32768,
    parameter int AUDIT_DIV = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_ce,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pfail_in,
    output logic              audit_out
);
    logic tick, audit_sq, hold, halt, aud_sel, load, year_wrap;
    tod_t live, shadow;

    rtc_prescaler #(.TICK_DIV(TICK_DIV), .AUDIT_DIV(AUDIT_DIV)) u_pre (
        .clk(clk), .rst(rst), .osc_ce(osc_ce), .run(!halt),
        .tick(tick), .audit_sq(audit_sq)
    );

    rtc_tod_counters u_cnt (
        .clk(clk), .rst(rst), .adv(tick && !hold), .load(load),
        .load_val(shadow), .tod(live), .year_wrap(year_wrap)
    );

    rtc_regfile u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata),
        .we(bus_we), .re(bus_re), .live(live), .year_wrap(year_wrap),
        .rdata(bus_rdata), .hold(hold), .halt(halt), .aud_sel(aud_sel),
        .load(load), .shadow(shadow)
    );

    assign audit_out = aud_sel ? audit_sq : pfail_in;

    AST_HALT_STOPS_TIME: assert property (@(posedge clk) disable iff (rst)
        (halt && !load) |=> $stable(live)); // R7

endmodule

// File: tb/rtc_shadow_core_tb.sv
`timescale 1ns/1ps
module rtc_shadow_core_tb;
    localparam int DIV = 8;
    localparam int ADIV = 4;

    logic clk = 1'b0;
    logic rst, osc_ce, we, re, pfail, audit;
    logic [3:0] addr;
    logic [7:0] wdata, rdata, calb, v;
    int total = 0, bad = 0;
    int rs, rm, rh, rw, rd, rmo, ry;

    always #2 clk = ~clk;

    rtc_shadow_core #(.TICK_DIV(DIV), .AUDIT_DIV(ADIV)) u_dut (
        .clk(clk), .rst(rst), .osc_ce(osc_ce), .bus_addr(addr),
        .bus_wdata(wdata), .bus_we(we), .bus_re(re), .bus_rdata(rdata),
        .pfail_in(pfail), .audit_out(audit)
    );

    function automatic int bcd(input int x);
        return ((x / 10) << 4) | (x % 10);
    endfunction

    function automatic int dim(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ref_tick();
        rs++;
        if (rs == 60) begin
            rs = 0; rm++;
            if (rm == 60) begin
                rm = 0; rh++;
                if (rh == 24) begin
                    rh = 0; rw = (rw == 7) ? 1 : rw + 1; rd++;
                    if (rd > dim(rmo, ry)) begin
                        rd = 1; rmo++;
                        if (rmo == 13) begin
                            rmo = 1; ry = (ry + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] o);
        @(negedge clk); addr = a; #1 o = rdata;
    endtask

    task automatic read_clr(input logic [3:0] a, output logic [7:0] o);
        @(negedge clk); addr = a; re = 1'b1; #1 o = rdata;
        @(negedge clk); re = 1'b0;
    endtask

    task automatic run_ce(input int n);
        @(negedge clk); osc_ce = 1'b1;
        repeat (n) @(negedge clk);
        osc_ce = 1'b0;
    endtask

    task automatic advance(input int n);
        run_ce(n * DIV);
        repeat (n) ref_tick();
    endtask

    task automatic load_time(input int s, input int mi, input int h, input int w,
                             input int d, input int mo, input int y);
        write_reg(4'h0, calb | 8'h02);
        write_reg(4'h2, 8'(bcd(s)));
        write_reg(4'h3, 8'(bcd(mi)));
        write_reg(4'h4, 8'(bcd(h)));
        write_reg(4'h5, 8'(w));
        write_reg(4'h6, 8'(bcd(d)));
        write_reg(4'h7, 8'(bcd(mo)));
        write_reg(4'h8, 8'(bcd(y)));
        write_reg(4'h0, calb);
        rs = s; rm = mi; rh = h; rw = w; rd = d; rmo = mo; ry = y;
    endtask

    task automatic snap_check(input string req);
        logic [7:0] o;
        write_reg(4'h0, calb | 8'h01);
        write_reg(4'h0, calb);
        peek(4'h2, o); chk(req, o, bcd(rs));
        peek(4'h3, o); chk(req, o, bcd(rm));
        peek(4'h4, o); chk(req, o, bcd(rh));
        peek(4'h5, o); chk(req, o, rw);
        peek(4'h6, o); chk(req, o, bcd(rd));
        peek(4'h7, o); chk(req, o, bcd(rmo));
        peek(4'h8, o); chk(req, o, bcd(ry));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ys[5] = '{0, 3, 4, 98, 99};
        int toggles;
        logic prev;
        rst = 1'b1; osc_ce = 1'b0; we = 1'b0; re = 1'b0; pfail = 1'b0;
        addr = '0; wdata = '0; calb = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        rs = 0; rm = 0; rh = 0; rw = 1; rd = 1; rmo = 1; ry = 0;
        peek(4'h0, v); chk("R11", v, 8'h00);
        peek(4'h1, v); chk("R11", v, 8'h80);
        peek(4'h2, v); chk("R11", v, 0);
        peek(4'h5, v); chk("R11", v, 1);
        peek(4'h6, v); chk("R11", v, 1);
        peek(4'h7, v); chk("R11", v, 1);

        // R7 halted after reset: enables make no second
        run_ce(3 * DIV);
        snap_check("R7");

        // R8 calibration fields, which also starts the clock
        write_reg(4'h1, 8'h45);
        peek(4'h1, v); chk("R8", v, 8'h45);

        // R12 one second per DIV enables
        run_ce(DIV - 1);
        write_reg(4'h0, 8'h01); write_reg(4'h0, 8'h00);
        peek(4'h2, v); chk("R12", v, 0);
        run_ce(1); ref_tick();
        snap_check("R12");

        // R3 capture on rising edge only
        advance(4);
        snap_check("R3");
        write_reg(4'h0, 8'h01);
        advance(2);
        peek(4'h2, v); chk("R3", v, bcd(rs - 2));
        write_reg(4'h0, 8'h01);
        peek(4'h2, v); chk("R3", v, bcd(rs - 2));
        write_reg(4'h0, 8'h00);
        snap_check("R3");

        // R4 hold drops seconds
        write_reg(4'h0, 8'h02);
        run_ce(3 * DIV);
        write_reg(4'h0, 8'h03);
        write_reg(4'h0, 8'h02);
        peek(4'h2, v); chk("R4", v, bcd(rs));
        write_reg(4'h0, 8'h00);
        advance(1);
        snap_check("R4");

        // R5 load on hold release, then R2 rollover
        load_time(58, 59, 23, 7, 28, 2, 99);
        snap_check("R5");
        advance(2);
        snap_check("R2");

        // R1 bit 7 dropped, then sweep every seconds value
        write_reg(4'h2, 8'hD9);
        peek(4'h2, v); chk("R1", v, 8'h59);
        load_time(0, 58, 10, 3, 15, 6, 50);
        for (int i = 0; i < 62; i++) begin
            advance(1);
            snap_check("R1");
        end

        // R2 month-end sweep over several years
        foreach (ys[k]) begin
            for (int mo = 1; mo <= 12; mo++) begin
                load_time(59, 59, 23, mo % 7 + 1, dim(mo, ys[k]), mo, ys[k]);
                advance(1);
                snap_check("R2");
            end
        end
        load_time(59, 59, 23, 3, 28, 2, 4);
        advance(1);
        snap_check("R2");

        // R6 century flag set by sweep, write ignored, read clears
        peek(4'h0, v); chk("R6", v[6], 1);
        write_reg(4'h0, calb);
        peek(4'h0, v); chk("R6", v[6], 1);
        read_clr(4'h0, v); chk("R6", v[6], 1);
        peek(4'h0, v); chk("R6", v[6], 0);

        // R6 rollover and clearing read in the same cycle
        load_time(59, 59, 23, 5, 31, 12, 99);
        run_ce(DIV - 1);
        @(negedge clk); osc_ce = 1'b1; addr = 4'h0; re = 1'b1;
        @(negedge clk); osc_ce = 1'b0; re = 1'b0;
        ref_tick();
        peek(4'h0, v); chk("R6", v[6], 1);
        snap_check("R6");
        read_clr(4'h0, v);
        peek(4'h0, v); chk("R6", v[6], 0);

        // R10 reserved and unmapped read zero
        write_reg(4'h0, 8'hF8);
        peek(4'h0, v); chk("R10", v, 8'h00);
        peek(4'hC, v); chk("R10", v, 8'h00);
        peek(4'hF, v); chk("R10", v, 8'h00);

        // R7 halt again mid-run
        write_reg(4'h1, 8'hC5);
        run_ce(2 * DIV);
        snap_check("R7");
        peek(4'h1, v); chk("R8", v, 8'hC5);
        write_reg(4'h1, 8'h45);

        // R9 audit output
        @(negedge clk); pfail = 1'b1; #1 chk("R9", audit, 1);
        @(negedge clk); pfail = 1'b0; #1 chk("R9", audit, 0);
        calb = 8'h04;
        write_reg(4'h0, calb);
        toggles = 0;
        prev = audit;
        @(negedge clk); osc_ce = 1'b1;
        for (int i = 0; i < 2 * ADIV; i++) begin
            @(negedge clk); #1;
            if (audit != prev) toggles++;
            prev = audit;
        end
        osc_ce = 1'b0;
        ref_tick();
        chk("R9", toggles, 4);
        pfail = 1'b1;
        @(negedge clk); #1 chk("R9", audit, prev);
        snap_check("R12");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule